// File: doc/BRIEF.md
# Multi-line tagged receive queue

This block gathers receive traffic from up to sixteen asynchronous serial lines into one shared queue that a host drains one 16-bit word at a time. Three kinds of entry share the queue: characters received on a line, each with its error flags; records of a change on a line's modem inputs; and the fixed self-test records that a master reset loads. Every entry is tagged with its line number and a three-bit code, so the host can tell the kinds apart.

The deserializers sit outside the block. Each line gives a one-cycle strobe with a character and its framing and parity flags, plus four modem input levels and a per-line link-type enable. Each line has a one-entry holding slot for characters and one for modem records. A fixed priority encoder moves one slot per cycle into the queue. The host side is a stream: `rd_word` always shows the head entry and its bit 15 is the valid flag. `rd_req` is the ready signal. A word is consumed at a clock edge where `rd_req` is high and bit 15 is set. Asserting `rd_req` while bit 15 is clear does nothing. The lines cannot be back-pressured, so a loss is reported with an overrun flag instead.

Top module: `mux_rx_queue`

## Requirements
- R1: `rd_word` shows valid in bit 15, the code in bits 14:12, the line number in bits 11:8 and the payload in bits 7:0. While the queue is empty the whole word reads as zero.
- R2: Entries come out in the order they were accepted. Each word is consumed by one `rd_req` cycle while bit 15 is set, and the host drains the queue by reading until bit 15 comes back clear.
- R3: The queue holds 64 entries. An entry offered to a full queue is dropped and the overrun flag is armed.
- R4: A character entry carries overrun in bit 14, framing error in bit 13 and parity error in bit 12. A clean character has code 000. A break arrives as character 0x00 with bit 13 set.
- R5: An armed overrun flag is reported on the next accepted character entry that has no framing error, and is then cleared. It never appears on modem or self-test entries.
- R6: When a line's `link_en` bit is high, any change of its modem levels queues a code 110 entry. Its payload holds the new levels: bit 0 CTS, bit 1 DCD, bit 2 DSR, bit 3 RI, and bits 7:4 zero. With `link_en` low, changes queue nothing.
- R7: Pending slots enter the queue one per cycle, lowest line first. Within one line the character goes before the modem record.
- R8: A strobe that arrives while the line's previous character is still waiting in its slot is discarded and arms the overrun flag.
- R9: A `mreset` pulse empties the queue and then loads exactly eight code 111 entries on line 0. `reset_busy` is high for the eight cycles of that load.
- R10: Self-test entries 0 and 1 are version records: bit 7 clear, bit 1 = entry index bit 0, bits 6:2 = ROM_VERSION. Entries 2 to 7 are pass records: bit 7 set, bits 4:2 zero, bit 1 = entry index bit 0.
- R11: `rx_irq` is high exactly when `rx_ie` is high and the queue holds at least one entry.
- R12: Line traffic that arrives during the self-test load waits in its slots and is queued after the eight self-test entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; empties the queue |
| mreset | input | 1 | Master reset pulse: empties the queue, then loads the self-test entries |
| reset_busy | output | 1 | High while the self-test entries are being loaded |
| rx_strb | input | NLINES | Per-line character strobe |
| rx_char | input | NLINES*8 | Per-line received character, line i in bits 8i+7:8i |
| rx_ferr | input | NLINES | Per-line framing error flag |
| rx_perr | input | NLINES | Per-line parity error flag |
| link_en | input | NLINES | Per-line enable for modem change entries |
| modem_lvl | input | NLINES*4 | Per-line modem levels {RI,DSR,DCD,CTS} |
| rd_req | input | 1 | Host ready: consumes the head word when it is valid |
| rd_word | output | 16 | Head word, bit 15 valid |
| rx_ie | input | 1 | Receive interrupt enable |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A corrupted read pointer or entry count shows at the host port as soon as the queue is read. The words come out duplicated, missing or out of order, or bit 15 stays set after the last expected entry. A wrong arbitration state shows within the length of one burst, as lines coming out in an order other than ascending. A stuck or misrouted overrun flag shows in bit 14 of the first clean character after a loss, or on an entry that should have been clean. A sequencer fault in the self-test load shows in the first eight words after `mreset` and in the length of the `reset_busy` window.

// File: rtl/mrxq_pkg.sv
package mrxq_pkg;
  localparam int WORD_W      = 16;
  localparam int ENTRY_W     = 15;
  localparam int LINE_W      = 4;
  localparam int DIAG_WORDS  = 8;
  localparam int DIAG_IDX_W  = $clog2(DIAG_WORDS);

  localparam logic [2:0] CODE_DIAG  = 3'b111;
  localparam logic [2:0] CODE_MODEM = 3'b110;

  typedef struct packed {
    logic [2:0]        code;
    logic [LINE_W-1:0] line;
    logic [7:0]        payload;
  } entry_t;

  // Payload of self-test entry number idx: two version records, then pass records.
  function automatic logic [7:0] diag_payload(input logic [DIAG_IDX_W-1:0] idx,
                                              input logic [4:0] ver);
    if (idx < 2) return {1'b0, ver, idx[0], 1'b0};
    else         return {1'b1, 2'b00, 3'b000, idx[0], 1'b0};
  endfunction
endpackage

// File: rtl/mrxq_line_slot.sv
module mrxq_line_slot (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       strb,
  input  logic [7:0] char_in,
  input  logic       fe_in,
  input  logic       pe_in,
  input  logic       link_en,
  input  logic [3:0] mdm_in,
  input  logic       gnt_data,
  input  logic       gnt_mdm,
  output logic       req_data,
  output logic       req_mdm,
  output logic [7:0] char_q,
  output logic       fe_q,
  output logic       pe_q,
  output logic [3:0] mdm_q,
  output logic       lost
);
  logic [3:0] mdm_prev;
  logic       mdm_chg;
  logic       slot_free;

  assign mdm_chg   = link_en && (mdm_in != mdm_prev);
  assign slot_free = !req_data || gnt_data;
  assign lost      = strb && !slot_free && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_data <= 1'b0;
      char_q   <= '0;
      fe_q     <= 1'b0;
      pe_q     <= 1'b0;
    end else if (flush) begin
      req_data <= 1'b0;
    end else if (strb && slot_free) begin
      req_data <= 1'b1;
      char_q   <= char_in;
      fe_q     <= fe_in;
      pe_q     <= pe_in;
    end else if (gnt_data) begin
      req_data <= 1'b0;
    end
  end

  // A newer change replaces a waiting modem record: the latest levels win.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdm_prev <= '0;
      req_mdm  <= 1'b0;
      mdm_q    <= '0;
    end else begin
      mdm_prev <= mdm_in;
      if (flush) begin
        req_mdm <= 1'b0;
      end else if (mdm_chg) begin
        req_mdm <= 1'b1;
        mdm_q   <= mdm_in;
      end else if (gnt_mdm) begin
        req_mdm <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mrxq_prio_arb.sv
module mrxq_prio_arb #(
  parameter int N = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             en,
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
    any = en && (|req);
    gnt = any ? ({{(N-1){1'b0}}, 1'b1} << idx) : '0;
  end
endmodule

// File: rtl/mrxq_fifo.sv
module mrxq_fifo #(
  parameter int W     = 15,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         accepted
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          rd_en;

  assign empty    = (count == '0);
  assign full     = (count == (AW+1)'(DEPTH));
  assign rd_en    = pop && !empty;
  assign accepted = push && (!full || rd_en);
  assign dout     = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (accepted && !flush) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accepted) wr_ptr <= nxt(wr_ptr);
      if (rd_en)    rd_ptr <= nxt(rd_ptr);
      case ({accepted, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mux_rx_queue.sv
module mux_rx_queue
  import mrxq_pkg::*;
#(
  parameter int         NLINES      = 16,
  parameter int         DEPTH       = 64,
  parameter logic [4:0] ROM_VERSION = 5'd9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mreset,
  output logic                  reset_busy,
  input  logic [NLINES-1:0]     rx_strb,
  input  logic [NLINES*8-1:0]   rx_char,
  input  logic [NLINES-1:0]     rx_ferr,
  input  logic [NLINES-1:0]     rx_perr,
  input  logic [NLINES-1:0]     link_en,
  input  logic [NLINES*4-1:0]   modem_lvl,
  input  logic                  rd_req,
  output logic [WORD_W-1:0]     rd_word,
  input  logic                  rx_ie,
  output logic                  rx_irq
);
  localparam int NREQ  = 2 * NLINES;
  localparam int IDX_W = $clog2(NREQ);
  localparam int SEL_W = IDX_W - 1;

  logic [NREQ-1:0]   arb_req, arb_gnt;
  logic [IDX_W-1:0]  arb_idx;
  logic              arb_any;
  logic [NLINES-1:0] lost_vec;
  logic [7:0]        slot_char [NLINES];
  logic [3:0]        slot_mdm  [NLINES];
  logic [NLINES-1:0] slot_fe, slot_pe;

  logic                  diag_active;
  logic [DIAG_IDX_W-1:0] diag_idx;
  logic                  ovr_pend;

  logic [SEL_W-1:0]  sel_line;
  logic              sel_mdm, sel_fe, sel_ovr;
  entry_t            push_entry, head_entry;
  logic              push, fifo_empty, fifo_full, fifo_acc;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    mrxq_line_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (mreset),
      .strb     (rx_strb[i]),
      .char_in  (rx_char[i*8 +: 8]),
      .fe_in    (rx_ferr[i]),
      .pe_in    (rx_perr[i]),
      .link_en  (link_en[i]),
      .mdm_in   (modem_lvl[i*4 +: 4]),
      .gnt_data (arb_gnt[2*i]),
      .gnt_mdm  (arb_gnt[2*i+1]),
      .req_data (arb_req[2*i]),
      .req_mdm  (arb_req[2*i+1]),
      .char_q   (slot_char[i]),
      .fe_q     (slot_fe[i]),
      .pe_q     (slot_pe[i]),
      .mdm_q    (slot_mdm[i]),
      .lost     (lost_vec[i])
    );
  end

  // Request index 2*line+kind: ascending index gives line order, character first.
  mrxq_prio_arb #(.N(NREQ)) u_arb (
    .en  (!diag_active && !mreset),
    .req (arb_req),
    .gnt (arb_gnt),
    .idx (arb_idx),
    .any (arb_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diag_active <= 1'b0;
      diag_idx    <= '0;
    end else if (mreset) begin
      diag_active <= 1'b1;
      diag_idx    <= '0;
    end else if (diag_active) begin
      diag_idx <= diag_idx + 1'b1;
      if (diag_idx == DIAG_IDX_W'(DIAG_WORDS - 1)) diag_active <= 1'b0;
    end
  end

  assign sel_line = arb_idx[IDX_W-1:1];
  assign sel_mdm  = arb_idx[0];
  assign sel_fe   = slot_fe[sel_line];
  assign sel_ovr  = ovr_pend && !sel_fe;

  always_comb begin
    if (diag_active) begin
      push_entry = '{code: CODE_DIAG, line: '0, payload: diag_payload(diag_idx, ROM_VERSION)};
    end else if (sel_mdm) begin
      push_entry = '{code: CODE_MODEM, line: LINE_W'(sel_line),
                     payload: {4'b0000, slot_mdm[sel_line]}};
    end else begin
      push_entry = '{code: {sel_ovr, sel_fe, slot_pe[sel_line]}, line: LINE_W'(sel_line),
                     payload: slot_char[sel_line]};
    end
  end

  assign push = diag_active || arb_any;

  // Overrun is armed by any loss and disarmed once a character without a framing error carries it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_pend <= 1'b0;
    end else if (mreset) begin
      ovr_pend <= 1'b0;
    end else if ((|lost_vec) || (arb_any && !fifo_acc)) begin
      ovr_pend <= 1'b1;
    end else if (arb_any && fifo_acc && !sel_mdm && sel_ovr) begin
      ovr_pend <= 1'b0;
    end
  end

  mrxq_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (mreset),
    .push     (push),
    .pop      (rd_req),
    .din      (push_entry),
    .dout     (head_entry),
    .empty    (fifo_empty),
    .full     (fifo_full),
    .accepted (fifo_acc)
  );

  assign rd_word    = fifo_empty ? '0 : {1'b1, head_entry};
  assign rx_irq     = rx_ie && !fifo_empty;
  assign reset_busy = diag_active;
endmodule

// File: rtl/mux_rx_queue_chk.sv
module mux_rx_queue_chk #(
  parameter int NREQ = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mreset,
  input logic            rd_req,
  input logic [15:0]     rd_word,
  input logic            rx_ie,
  input logic            rx_irq,
  input logic            reset_busy,
  input logic            fifo_full,
  input logic [NREQ-1:0] arb_gnt
);
  p_empty_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_word[15] |-> (rd_word == 16'h0000));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !rd_req && !mreset) |=> fifo_full);

  p_modem_high_nibble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word[15] && rd_word[14:12] == 3'b110) |-> (rd_word[7:4] == 4'h0));

  p_one_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arb_gnt));

  p_diag_line0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word[15] && rd_word[14:12] == 3'b111) |-> (rd_word[11:8] == 4'h0));

  p_busy_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reset_busy) |-> $past(reset_busy, 8));

  p_no_grant_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    reset_busy |-> (arb_gnt == '0));

  p_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq == (rx_ie && rd_word[15]));
endmodule

bind mux_rx_queue mux_rx_queue_chk #(.NREQ(2*NLINES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mreset     (mreset),
  .rd_req     (rd_req),
  .rd_word    (rd_word),
  .rx_ie      (rx_ie),
  .rx_irq     (rx_irq),
  .reset_busy (reset_busy),
  .fifo_full  (fifo_full),
  .arb_gnt    (arb_gnt)
);

// File: tb/mux_rx_queue_tb.sv
module mux_rx_queue_tb;
  localparam int         NL   = 16;
  localparam logic [4:0] ROMV = 5'd9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mreset = 1'b0;
  logic          reset_busy;
  logic [NL-1:0]   rx_strb = '0;
  logic [NL*8-1:0] rx_char = '0;
  logic [NL-1:0]   rx_ferr = '0;
  logic [NL-1:0]   rx_perr = '0;
  logic [NL-1:0]   link_en = '0;
  logic [NL*4-1:0] modem_lvl = '0;
  logic          rd_req = 1'b0;
  logic [15:0]   rd_word;
  logic          rx_ie = 1'b0;
  logic          rx_irq;

  int checks = 0;
  int fails  = 0;
  logic [15:0] expq[$];

  always #2.5 clk = ~clk;

  mux_rx_queue u_dut (
    .clk(clk), .rst_n(rst_n), .mreset(mreset), .reset_busy(reset_busy),
    .rx_strb(rx_strb), .rx_char(rx_char), .rx_ferr(rx_ferr), .rx_perr(rx_perr),
    .link_en(link_en), .modem_lvl(modem_lvl), .rd_req(rd_req), .rd_word(rd_word),
    .rx_ie(rx_ie), .rx_irq(rx_irq)
  );

  function automatic logic [15:0] exp_char(logic ovr, logic fe, logic pe, int ln, logic [7:0] c);
    return {1'b1, ovr, fe, pe, 4'(ln), c};
  endfunction

  function automatic logic [15:0] exp_mdm(int ln, logic [3:0] lv);
    return {1'b1, 3'b110, 4'(ln), 4'h0, lv};
  endfunction

  function automatic logic [15:0] exp_diag(int i);
    logic [7:0] p;
    if (i < 2) p = {1'b0, ROMV, 1'(i), 1'b0};
    else       p = {1'b1, 5'b00000, 1'(i), 1'b0};
    return {1'b1, 3'b111, 4'h0, p};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_word(output logic [15:0] w);
    w = rd_word;
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic drain(input string req);
    logic [15:0] w;
    while (expq.size() > 0) begin
      read_word(w);
      chk(req, w, expq.pop_front());
    end
    chk({req, " empty after drain (R1)"}, rd_word, 16'h0000);
  endtask

  task automatic put_char(input int ln, input logic [7:0] c, input logic fe, input logic pe);
    rx_strb[ln] = 1'b1;
    rx_char[ln*8 +: 8] = c;
    rx_ferr[ln] = fe;
    rx_perr[ln] = pe;
    @(negedge clk);
    rx_strb = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    logic [15:0] w;
    logic [7:0] c;
    logic [7:0] fullq[$];
    void'($urandom(32'd7301));

    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 R11: reset state
    chk("R1 reset word", rd_word, 16'h0000);
    rx_ie = 1'b1;
    wait_cyc(1);
    chk("R11 irq empty", {15'b0, rx_irq}, 16'h0000);
    chk("R9 busy after reset", {15'b0, reset_busy}, 16'h0000);

    // R9 R10: master reset loads self-test entries
    mreset = 1'b1;
    wait_cyc(1);
    mreset = 1'b0;
    n = 0;
    while (reset_busy && n < 50) begin
      n++;
      wait_cyc(1);
    end
    chk("R9 busy cycles", 16'(n), 16'd8);
    chk("R11 irq nonempty", {15'b0, rx_irq}, 16'h0001);
    rx_ie = 1'b0;
    wait_cyc(1);
    chk("R11 irq disabled", {15'b0, rx_irq}, 16'h0000);
    rx_ie = 1'b1;
    for (int i = 0; i < 8; i++) expq.push_back(exp_diag(i));
    drain("R10 diag words");

    // R4: break and flag encodings
    put_char(7, 8'h00, 1'b1, 1'b0);
    put_char(7, 8'h5A, 1'b0, 1'b1);
    put_char(7, 8'hC3, 1'b0, 1'b0);
    wait_cyc(3);
    expq.push_back(exp_char(1'b0, 1'b1, 1'b0, 7, 8'h00));
    expq.push_back(exp_char(1'b0, 1'b0, 1'b1, 7, 8'h5A));
    expq.push_back(exp_char(1'b0, 1'b0, 1'b0, 7, 8'hC3));
    drain("R4 char flags");

    // R6: modem change with and without link enable
    link_en[5] = 1'b1;
    wait_cyc(1);
    modem_lvl[5*4 +: 4] = 4'b1010;
    modem_lvl[6*4 +: 4] = 4'b0111;
    wait_cyc(4);
    expq.push_back(exp_mdm(5, 4'b1010));
    drain("R6 modem record");
    link_en[6] = 1'b1;
    wait_cyc(4);
    chk("R6 no record without change", rd_word, 16'h0000);

    // R7: priority across and within lines
    link_en[2] = 1'b1;
    link_en[3] = 1'b1;
    wait_cyc(1);
    modem_lvl[2*4 +: 4] = 4'b0011;
    modem_lvl[3*4 +: 4] = 4'b0101;
    put_char(3, 8'h33, 1'b0, 1'b0);
    wait_cyc(5);
    expq.push_back(exp_mdm(2, 4'b0011));
    expq.push_back(exp_char(1'b0, 1'b0, 1'b0, 3, 8'h33));
    expq.push_back(exp_mdm(3, 4'b0101));
    drain("R7 within-line order");

    // R2 R4 R7: random same-cycle bursts
    for (int b = 0; b < 30; b++) begin
      logic [NL-1:0] mask;
      mask = NL'($urandom);
      if (mask == '0) mask = NL'(1);
      for (int ln = 0; ln < NL; ln++) begin
        logic [7:0] rc;
        logic rf, rp;
        rc = 8'($urandom);
        rf = 1'($urandom);
        rp = 1'($urandom);
        rx_strb[ln] = mask[ln];
        rx_char[ln*8 +: 8] = rc;
        rx_ferr[ln] = rf;
        rx_perr[ln] = rp;
        if (mask[ln]) expq.push_back(exp_char(1'b0, rf, rp, ln, rc));
      end
      wait_cyc(1);
      rx_strb = '0;
      wait_cyc(20);
      drain("R7 burst order");
    end

    // R8 R12: traffic during self-test load
    mreset = 1'b1;
    wait_cyc(1);
    mreset = 1'b0;
    put_char(4, 8'hA1, 1'b0, 1'b0);
    put_char(4, 8'hB2, 1'b0, 1'b0);
    wait_cyc(12);
    for (int i = 0; i < 8; i++) expq.push_back(exp_diag(i));
    expq.push_back(exp_char(1'b1, 1'b0, 1'b0, 4, 8'hA1));
    drain("R8 R12 slot loss after diag");

    // R3 R2: fill to 64, overflow, drain in order
    for (int i = 0; i < 64; i++) begin
      c = 8'($urandom);
      fullq.push_back(c);
      put_char(1, c, 1'b0, 1'b0);
      wait_cyc(1);
    end
    for (int i = 0; i < 3; i++) begin
      put_char(1, 8'hEE, 1'b0, 1'b0);
      wait_cyc(1);
    end
    chk("R11 irq full", {15'b0, rx_irq}, 16'h0001);
    for (int i = 0; i < 64; i++) expq.push_back(exp_char(1'b0, 1'b0, 1'b0, 1, fullq[i]));
    drain("R3 full queue contents");

    // R5: overrun deferred past framing error and modem record
    put_char(9, 8'h00, 1'b1, 1'b0);
    wait_cyc(2);
    link_en[9] = 1'b1;
    wait_cyc(1);
    modem_lvl[9*4 +: 4] = 4'b0001;
    wait_cyc(3);
    put_char(9, 8'h41, 1'b0, 1'b0);
    put_char(9, 8'h42, 1'b0, 1'b0);
    wait_cyc(3);
    expq.push_back(exp_char(1'b0, 1'b1, 1'b0, 9, 8'h00));
    expq.push_back(exp_mdm(9, 4'b0001));
    expq.push_back(exp_char(1'b1, 1'b0, 1'b0, 9, 8'h41));
    expq.push_back(exp_char(1'b0, 1'b0, 1'b0, 9, 8'h42));
    drain("R5 overrun carry");
    chk("R11 irq after drain", {15'b0, rx_irq}, 16'h0000);

    finish_run();
  end
endmodule